// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a counting watchdog with two thresholds, mapped onto a simple word-addressed register bus. Once software sets the enable bit it counts clock ticks. At the first threshold (the warning level) it raises a level interrupt, which gives software a chance to act before the second threshold (the reset level). At that point it emits a one-cycle system reset request. Software keeps the system alive by writing a 1 to the reload register, which returns the count to zero.

A status bit records that a watchdog expiry caused the most recent reset. It sits on the power-on reset only, so it survives the system reset that the block itself requests. Software is expected to disable the block, reload the count, write the warning level, write the reset level and then enable. Setting both levels to the same value makes the interrupt and the reset request fire in the same cycle.

Top module: `wdog_top`

## Requirements
- R1: After power-on reset, `barkIrq` and `biteRst` are 0 and reads of byte offsets 0x4, 0x8, 0xC, 0x10 and 0x14 all return 0. When no read is in progress (`busSel` low or `busWr` high), `busRdata` is 0.
- R2: The warning level register (offset 0x10) and the reset level register (offset 0x14) read back the last value written to them.
- R3: Writing 1 to bit 0 of the enable register (offset 0x8) starts counting. The count is 0 in the cycle after the enabling write and rises by one at each later clock edge. `barkIrq` goes high exactly N edges after the enabling write, where N is the warning level, and the enable register reads back 1.
- R4: A write at offset 0x4 with bit 0 set clears the count at that edge. `barkIrq` falls in the next cycle and rises again N edges after the reload.
- R5: A write at offset 0x4 with bit 0 clear has no effect on the count: `barkIrq` stays high.
- R6: `biteRst` is high for exactly one cycle, M edges after the enabling write, where M is the reset level. The count then saturates at M and no further pulse follows while the block stays enabled.
- R7: Writing 0 to enable bit 0 forces `barkIrq` low in the next cycle and freezes the count. Re-enabling resumes from the frozen count.
- R8: Status bit 0 (offset 0xC) becomes 1 after a reset-level expiry. It stays 1 through `sysRstN` and is cleared only by `porRstN`.
- R9: `sysRstN` low at a clock edge clears the enable bit, both level registers and the count, so `barkIrq` and `biteRst` are low afterwards.
- R10: With equal warning and reset levels, `barkIrq` and `biteRst` both rise at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and register clock |
| porRstN | input | 1 | Power-on reset, active low, synchronous; clears everything including status |
| sysRstN | input | 1 | System reset, active low, synchronous; clears everything except status |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (5) | Byte offset of the register |
| busWdata | input | DATA_W (32) | Write data |
| busRdata | output | DATA_W (32) | Read data, combinational, 0 when not reading |
| barkIrq | output | 1 | Warning interrupt, level high |
| biteRst | output | 1 | One-cycle system reset request |

## Verification
The count is driven with several level pairs: a warning level well below the reset level, equal levels, and a pause by disabling partway to the warning level. Edge-exact sampling around each threshold separates an off-by-one compare from a correct one. Separate scenarios tell apart a reload from an ignored reload write, a held count from a restarted one, and a single reset pulse from a repeating one. A system reset placed between an expiry and a power-on reset shows that the status bit lives in the correct reset domain.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int OFF_PING = 4;
  localparam int OFF_EN   = 8;
  localparam int OFF_STS  = 12;
  localparam int OFF_BARK = 16;
  localparam int OFF_BITE = 20;

  typedef struct packed {
    logic ping;
    logic enWr;
    logic barkWr;
    logic biteWr;
  } wdogStb_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrBit0,
  input  logic              enReg,
  input  logic              stsBit,
  input  logic [CNT_W-1:0]  barkVal,
  input  logic [CNT_W-1:0]  biteVal,
  output wdogStb_t          stb,
  output logic [DATA_W-1:0] busRdata
);
  logic wrHit, rdHit;

  always_comb begin
    wrHit = busSel && busWr;
    rdHit = busSel && !busWr;
    stb.ping   = wrHit && (busAddr == ADDR_W'(OFF_PING)) && wrBit0;
    stb.enWr   = wrHit && (busAddr == ADDR_W'(OFF_EN));
    stb.barkWr = wrHit && (busAddr == ADDR_W'(OFF_BARK));
    stb.biteWr = wrHit && (busAddr == ADDR_W'(OFF_BITE));
  end

  always_comb begin
    busRdata = '0;
    if (rdHit) begin
      unique case (busAddr)
        ADDR_W'(OFF_EN):   busRdata = DATA_W'(enReg);
        ADDR_W'(OFF_STS):  busRdata = DATA_W'(stsBit);
        ADDR_W'(OFF_BARK): busRdata = DATA_W'(barkVal);
        ADDR_W'(OFF_BITE): busRdata = DATA_W'(biteVal);
        default:           busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  wdogStb_t          stb,
  input  logic [DATA_W-1:0] wrData,
  output logic              enReg,
  output logic [CNT_W-1:0]  barkVal,
  output logic [CNT_W-1:0]  biteVal,
  output logic              stsBit,
  output logic              barkIrq,
  output logic              biteRst
);
  logic [CNT_W-1:0] count;
  logic biteDone;
  logic rstN;
  logic barkHit, biteHit;

  assign rstN    = porRstN & sysRstN;
  assign barkHit = count >= barkVal;
  assign biteHit = count >= biteVal;
  assign barkIrq = enReg && barkHit;
  assign biteRst = enReg && biteHit && !biteDone;

  // Registers cleared by either reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      barkVal  <= '0;
      biteVal  <= '0;
      count    <= '0;
      biteDone <= 1'b0;
    end else begin
      if (stb.enWr)   enReg   <= wrData[0];
      if (stb.barkWr) barkVal <= wrData[CNT_W-1:0];
      if (stb.biteWr) biteVal <= wrData[CNT_W-1:0];

      if (stb.ping)
        count <= '0;
      else if (enReg && !biteHit)
        count <= count + 1'b1;

      if (stb.ping || (stb.enWr && !wrData[0]))
        biteDone <= 1'b0;
      else if (biteRst)
        biteDone <= 1'b1;
    end
  end

  // Sticky cause bit, power-on domain only
  always_ff @(posedge clk) begin
    if (!porRstN)
      stsBit <= 1'b0;
    else if (biteRst)
      stsBit <= 1'b1;
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              barkIrq,
  output logic              biteRst
);
  wdogStb_t stb;
  logic enReg, stsBit;
  logic [CNT_W-1:0] barkVal, biteVal;

  wdog_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .wrBit0(busWdata[0]),
    .enReg(enReg), .stsBit(stsBit), .barkVal(barkVal), .biteVal(biteVal),
    .stb(stb), .busRdata(busRdata)
  );

  wdog_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .stb(stb),
    .wrData(busWdata), .enReg(enReg), .barkVal(barkVal), .biteVal(biteVal),
    .stsBit(stsBit), .barkIrq(barkIrq), .biteRst(biteRst)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              porRstN,
  input logic              sysRstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic              wrBit0,
  input logic [DATA_W-1:0] busRdata,
  input logic              barkIrq,
  input logic              biteRst
);
  p_single_pulse_r6: assert property (@(posedge clk)
    disable iff (!porRstN || !sysRstN) biteRst |=> !biteRst);

  p_sysrst_quiet_r9: assert property (@(posedge clk)
    disable iff (!porRstN) !sysRstN |=> (!barkIrq && !biteRst));

  p_disable_quiet_r7: assert property (@(posedge clk)
    disable iff (!porRstN || !sysRstN)
    (busSel && busWr && busAddr == ADDR_W'(OFF_EN) && !wrBit0) |=> (!barkIrq && !biteRst));

  p_read_idle_r1: assert property (@(posedge clk)
    disable iff (!porRstN) !(busSel && !busWr) |-> (busRdata == '0));
endmodule

bind wdog_top wdog_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .busSel(busSel),
  .busWr(busWr), .busAddr(busAddr), .wrBit0(busWdata[0]),
  .busRdata(busRdata), .barkIrq(barkIrq), .biteRst(biteRst)
);

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic porRstN = 1'b0, sysRstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [4:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic barkIrq, biteRst;

  int nRun = 0, nFail = 0, pulseCnt = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  wdog_top dut (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .busSel(busSel),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .barkIrq(barkIrq), .biteRst(biteRst)
  );

  always @(negedge clk) if (biteRst) pulseCnt++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWr = 0; busWdata = '0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    busSel = 1; busWr = 0; busAddr = a;
    #1 d = busRdata;
    busSel = 0;
  endtask

  task automatic sysPulse();
    sysRstN = 0; tick(1); sysRstN = 1;
  endtask

  task automatic setup(int bark, int bite);
    sysPulse();
    wr(5'h08, 0); wr(5'h04, 1);
    wr(5'h10, bark); wr(5'h14, bite);
    wr(5'h08, 1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    porRstN = 0; sysRstN = 0; tick(2); porRstN = 1; sysRstN = 1;
    chk("R1 irq", barkIrq, 0);
    chk("R1 rst", biteRst, 0);
    foreach (d[i]) ;
    for (int a = 4; a <= 20; a += 4) begin
      rd(a[4:0], d); chk("R1 read", d, 0);
    end
    chk("R1 idle bus", busRdata, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    sysPulse();
    wr(5'h10, 32'h0ABC_1234); wr(5'h14, 32'h1000_0000);
    rd(5'h10, d); chk("R2 bark", d, 32'h0ABC_1234);
    rd(5'h14, d); chk("R2 bite", d, 32'h1000_0000);
  endtask

  task automatic t_bark();
    logic [31:0] d;
    setup(5, 100);
    rd(5'h08, d); chk("R3 en read", d, 1);
    tick(4); chk("R3 before bark", barkIrq, 0);
    tick(1); chk("R3 at bark", barkIrq, 1);
    tick(3); chk("R3 held", barkIrq, 1);
  endtask

  task automatic t_ping();
    setup(4, 100);
    tick(6); chk("R4 pre", barkIrq, 1);
    wr(5'h04, 32'hFFFF_FFFE); chk("R5 ignored ping", barkIrq, 1);
    wr(5'h04, 1); chk("R4 cleared", barkIrq, 0);
    tick(3); chk("R4 before rearm", barkIrq, 0);
    tick(1); chk("R4 rearm", barkIrq, 1);
  endtask

  task automatic t_bite();
    setup(3, 8);
    pulseCnt = 0;
    tick(7); chk("R6 before bite", biteRst, 0);
    tick(1); chk("R6 bite", biteRst, 1);
    tick(1); chk("R6 one cycle", biteRst, 0);
    tick(30); chk("R6 single pulse", pulseCnt, 1);
    chk("R6 irq stays", barkIrq, 1);
  endtask

  task automatic t_pause();
    setup(6, 100);
    tick(4);
    wr(5'h08, 0); chk("R7 off irq", barkIrq, 0);
    tick(20); chk("R7 frozen", barkIrq, 0);
    wr(5'h08, 1); chk("R7 resumed early", barkIrq, 0);
    tick(1); chk("R7 resumed", barkIrq, 1);
  endtask

  task automatic t_status();
    logic [31:0] d;
    setup(2, 4);
    tick(6);
    rd(5'h0C, d); chk("R8 set", d, 1);
    sysPulse();
    rd(5'h0C, d); chk("R8 survives sys", d, 1);
    rd(5'h08, d); chk("R9 en cleared", d, 0);
    rd(5'h10, d); chk("R9 bark cleared", d, 0);
    rd(5'h14, d); chk("R9 bite cleared", d, 0);
    chk("R9 quiet", {barkIrq, biteRst}, 0);
    porRstN = 0; tick(1); porRstN = 1;
    rd(5'h0C, d); chk("R8 por clears", d, 0);
  endtask

  task automatic t_same();
    setup(2, 2);
    tick(1); chk("R10 early", {barkIrq, biteRst}, 2'b00);
    tick(1); chk("R10 together", {barkIrq, biteRst}, 2'b11);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    tick(1);
    t_reset();
    t_readback();
    t_bark();
    t_ping();
    t_bite();
    t_pause();
    t_status();
    t_same();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule